// File: doc/BRIEF.md
# Read Response Payload Extractor

This block sits behind the receive side of a display serial link controller. Once a panel's reply to a read request has been captured into a 16-byte buffer, software or a sequencer pulses `start_i` together with that buffer and the number of bytes the caller asked for. The block decodes the data type in buffer byte 0 and derives the number of payload bytes from it. It picks where in the buffer the payload begins, limits the count, and then streams the selected bytes out one per clock with valid and last markers. It ends each transaction with a one-cycle done pulse.

The reply count and two error flags are captured on acceptance and held until the next accepted start. `retry_o` marks an acknowledge-with-error reply. `unknown_o` marks a data type the block does not recognise. Packet reception, ECC and checksum handling happen elsewhere.

The controller has three states. `ST_IDLE` waits for a start. On a start, *accept-to-send* moves to `ST_SEND` when the limited count is non-zero, and *accept-to-finish* moves directly to `ST_FINISH` when the count is zero. `ST_SEND` emits one byte per cycle and takes *send-to-finish* after the final byte. `ST_FINISH` raises done for one cycle and takes *finish-to-idle*.

Top module: `resp_payload_extract`

## Requirements
- R1: After reset, valid, last and done are low, and the reported count and both flags are zero.
- R2: Type 0x11 or 0x21 in buffer byte 0 gives a raw count of 1, and the payload is buffer byte 1.
- R3: Type 0x12 or 0x22 gives a raw count of 2, and the payload is buffer bytes 1 and 2.
- R4: Type 0x1A or 0x1C gives a raw count of byte1 + 16 × byte2, where byte1 is buffer byte 1 and byte2 is buffer byte 2.
- R5: When the raw count exceeds 2, the payload starts at buffer byte 4; otherwise it starts at buffer byte 1.
- R6: The raw count is first limited to at most 10 bytes.
- R7: That result is then limited to the requested length, and the final value is reported on `count_o`.
- R8: Type 0x02 gives a count of 0, emits no bytes, and sets `retry_o`.
- R9: Any other type gives a count of 0, emits no bytes, and sets `unknown_o`. `retry_o` and `unknown_o` are never set together.
- R10: Payload bytes leave in ascending buffer order on consecutive cycles, starting the cycle after the start is accepted. `last_o` is high only with the final byte.
- R11: `done_o` is high for exactly one cycle. That cycle is the one after the final byte, or the cycle after acceptance when the count is zero.
- R12: A start pulse while a transaction is in progress is ignored: the output bytes, count and flags stay those of the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept buffer and length (honoured in idle only) |
| rx_buf_i | input | 128 | Captured reply; byte k at bits 8k+7..8k |
| req_len_i | input | 8 | Number of bytes the caller wants |
| data_o | output | 8 | Payload byte |
| valid_o | output | 1 | `data_o` carries a payload byte |
| last_o | output | 1 | Final payload byte of this transaction |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| count_o | output | 4 | Final byte count of the latest accepted reply |
| retry_o | output | 1 | Latest reply was an acknowledge-with-error |
| unknown_o | output | 1 | Latest reply had an unrecognised type |

## Verification
The bench covers several boundaries:
- A long reply whose length is exactly 2. A design that chose the offset from the type rather than the count would read from byte 4 here.
- A long reply of 16 bytes and one of the maximum length. A design that truncated the wide length sum, or that limited by the requested length before the fixed cap, would stream the wrong number of bytes.
- Requested lengths of 0, 1 and 3 against longer replies. These expose a missing second limit and a broken zero-count path, which would either emit a byte or never pulse done.
- A start injected mid-stream. This catches a controller that re-latches the buffer outside idle, and so changes its bytes or flags partway through the transaction.

// File: rtl/resp_pkg.sv
package resp_pkg;
    localparam int BYTE_W   = 8;
    localparam int HI_SHIFT = 4;
    localparam int RAW_W    = BYTE_W + HI_SHIFT + 1;

    localparam logic [BYTE_W-1:0] TY_ACK_ERR  = 8'h02;
    localparam logic [BYTE_W-1:0] TY_GEN_ONE  = 8'h11;
    localparam logic [BYTE_W-1:0] TY_GEN_TWO  = 8'h12;
    localparam logic [BYTE_W-1:0] TY_GEN_LONG = 8'h1A;
    localparam logic [BYTE_W-1:0] TY_DCS_LONG = 8'h1C;
    localparam logic [BYTE_W-1:0] TY_DCS_ONE  = 8'h21;
    localparam logic [BYTE_W-1:0] TY_DCS_TWO  = 8'h22;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_FINISH
    } ext_state_e;

    typedef struct packed {
        logic [RAW_W-1:0] raw;
        logic             retry;
        logic             unknown;
    } decode_t;
endpackage

// File: rtl/resp_type_decode.sv
module resp_type_decode
    import resp_pkg::*;
(
    input  logic [BYTE_W-1:0] type_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] hi_i,
    output decode_t           dec_o
);
    always_comb begin
        dec_o = '0;
        unique case (type_i)
            TY_GEN_ONE, TY_DCS_ONE:   dec_o.raw = RAW_W'(1);
            TY_GEN_TWO, TY_DCS_TWO:   dec_o.raw = RAW_W'(2);
            TY_GEN_LONG, TY_DCS_LONG: dec_o.raw = RAW_W'(lo_i) + (RAW_W'(hi_i) << HI_SHIFT);
            TY_ACK_ERR:               dec_o.retry = 1'b1;
            default:                  dec_o.unknown = 1'b1;
        endcase
    end
endmodule

// File: rtl/resp_len_limit.sv
module resp_len_limit
    import resp_pkg::*;
#(
    parameter int MAX_PAYLOAD = 10,
    parameter int LEN_W       = 8,
    parameter int CNT_W       = 4,
    parameter int IDX_W       = 4,
    parameter int SHORT_MAX   = 2,
    parameter int NEAR_OFF    = 1,
    parameter int FAR_OFF     = 4
) (
    input  logic [RAW_W-1:0] raw_i,
    input  logic [LEN_W-1:0] req_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [IDX_W-1:0] off_o
);
    localparam int CMP_W = (RAW_W > LEN_W) ? RAW_W : LEN_W;

    logic [CMP_W-1:0] raw_ext, req_ext, capped, limited;

    always_comb begin
        raw_ext = CMP_W'(raw_i);
        req_ext = CMP_W'(req_i);
        // fixed cap first, caller's length second
        capped  = (raw_ext > CMP_W'(MAX_PAYLOAD)) ? CMP_W'(MAX_PAYLOAD) : raw_ext;
        limited = (req_ext < capped) ? req_ext : capped;
        cnt_o   = CNT_W'(limited);
        // offset follows the undecorated count, not the limited one
        off_o   = (raw_i > RAW_W'(SHORT_MAX)) ? IDX_W'(FAR_OFF) : IDX_W'(NEAR_OFF);
    end
endmodule

// File: rtl/resp_payload_extract.sv
module resp_payload_extract
    import resp_pkg::*;
#(
    parameter int BUF_BYTES   = 16,
    parameter int MAX_PAYLOAD = 10,
    parameter int LEN_W       = 8,
    localparam int CNT_W      = $clog2(MAX_PAYLOAD + 1),
    localparam int IDX_W      = $clog2(BUF_BYTES),
    localparam int BUF_W      = BYTE_W * BUF_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BUF_W-1:0]  rx_buf_i,
    input  logic [LEN_W-1:0]  req_len_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              valid_o,
    output logic              last_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              retry_o,
    output logic              unknown_o
);
    ext_state_e       state_q, state_d;
    logic [BUF_W-1:0] buf_q;
    logic [CNT_W-1:0] cnt_q, idx_q, cnt_new;
    logic [IDX_W-1:0] off_q, off_new, rd_pos;
    logic             retry_q, unknown_q, final_byte;
    decode_t          dec;

    resp_type_decode u_decode (
        .type_i (rx_buf_i[0 +: BYTE_W]),
        .lo_i   (rx_buf_i[BYTE_W +: BYTE_W]),
        .hi_i   (rx_buf_i[2*BYTE_W +: BYTE_W]),
        .dec_o  (dec)
    );

    resp_len_limit #(
        .MAX_PAYLOAD (MAX_PAYLOAD),
        .LEN_W       (LEN_W),
        .CNT_W       (CNT_W),
        .IDX_W       (IDX_W)
    ) u_limit (
        .raw_i (dec.raw),
        .req_i (req_len_i),
        .cnt_o (cnt_new),
        .off_o (off_new)
    );

    assign final_byte = (idx_q == cnt_q - CNT_W'(1));
    assign rd_pos     = off_q + IDX_W'(idx_q);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = (cnt_new == '0) ? ST_FINISH : ST_SEND;
            ST_SEND:   if (final_byte) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and captured reply
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            buf_q     <= '0;
            cnt_q     <= '0;
            off_q     <= '0;
            idx_q     <= '0;
            retry_q   <= 1'b0;
            unknown_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                buf_q     <= rx_buf_i;
                cnt_q     <= cnt_new;
                off_q     <= off_new;
                idx_q     <= '0;
                retry_q   <= dec.retry;
                unknown_q <= dec.unknown;
            end else if (state_q == ST_SEND) begin
                idx_q <= idx_q + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        valid_o   = (state_q == ST_SEND);
        last_o    = (state_q == ST_SEND) && final_byte;
        done_o    = (state_q == ST_FINISH);
        data_o    = buf_q[{rd_pos, 3'b000} +: BYTE_W];
        count_o   = cnt_q;
        retry_o   = retry_q;
        unknown_o = unknown_q;
    end
endmodule

// File: rtl/resp_payload_extract_chk.sv
module resp_payload_extract_chk #(
    parameter int MAX_PAYLOAD = 10,
    parameter int CNT_W       = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid_o,
    input logic             last_o,
    input logic             done_o,
    input logic [CNT_W-1:0] count_o,
    input logic             retry_o,
    input logic             unknown_o
);
    assert_count_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(MAX_PAYLOAD));

    assert_last_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    assert_stream_gapless_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o);

    assert_done_follows_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> done_o);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !valid_o);

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(retry_o && unknown_o));

    assert_error_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_o || unknown_o) |-> (!valid_o && count_o == '0));
endmodule

bind resp_payload_extract resp_payload_extract_chk #(
    .MAX_PAYLOAD (MAX_PAYLOAD),
    .CNT_W       (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_o   (valid_o),
    .last_o    (last_o),
    .done_o    (done_o),
    .count_o   (count_o),
    .retry_o   (retry_o),
    .unknown_o (unknown_o)
);

// File: tb/test_resp_payload_extract.sv
`timescale 1ns/1ps
module test_resp_payload_extract;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] rx_buf = '0;
    logic [7:0]   req_len = '0;
    logic [7:0]   data;
    logic         valid, last, done, retry, unknown;
    logic [3:0]   count;
    int           n_checks = 0;
    int           n_errors = 0;
    bit           finished = 1'b0;

    always #4 clk = ~clk;

    resp_payload_extract i_resp_payload_extract (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .rx_buf_i  (rx_buf),
        .req_len_i (req_len),
        .data_o    (data),
        .valid_o   (valid),
        .last_o    (last),
        .done_o    (done),
        .count_o   (count),
        .retry_o   (retry),
        .unknown_o (unknown)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mkbuf(input logic [7:0] ty, input logic [7:0] b1, input logic [7:0] b2);
        logic [127:0] b;
        for (int i = 0; i < 16; i++) b[8*i +: 8] = 8'(8'h40 + i * 13);
        b[7:0]   = ty;
        b[15:8]  = b1;
        b[23:16] = b2;
        return b;
    endfunction

    // independent reference built from the requirement text
    function automatic void model(input logic [127:0] b, input int req,
                                  output int n, output int off, output int rt, output int uk);
        int raw;
        raw = 0; rt = 0; uk = 0;
        case (b[7:0])
            8'h11, 8'h21: raw = 1;
            8'h12, 8'h22: raw = 2;
            8'h1A, 8'h1C: raw = int'(b[15:8]) + 16 * int'(b[23:16]);
            8'h02:        rt = 1;
            default:      uk = 1;
        endcase
        off = (raw > 2) ? 4 : 1;
        n = (raw > 10) ? 10 : raw;
        if (req < n) n = req;
    endfunction

    task automatic run_frame(input string tag, input logic [127:0] b, input int req,
                             input int inj_at, input logic [127:0] inj_b);
        int exp_n, exp_off, exp_rt, exp_uk;
        int got_n, done_c, last_c, last_cnt;
        model(b, req, exp_n, exp_off, exp_rt, exp_uk);
        got_n = 0; done_c = -1; last_c = -1; last_cnt = 0;
        @(negedge clk);
        rx_buf = b; req_len = 8'(req); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 40; c++) begin
            if (valid) begin
                if (got_n < exp_n)
                    chk(data == b[8*(exp_off+got_n) +: 8], tag, "byte order (R10)",
                        int'(data), int'(b[8*(exp_off+got_n) +: 8]));
                got_n++;
            end
            if (last) begin last_c = c; last_cnt++; end
            if (done) begin done_c = c; break; end
            if (c == inj_at) begin rx_buf = inj_b; start = 1'b1; end
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk(got_n == exp_n, tag, "byte count", got_n, exp_n);
        if (exp_n > 0) chk(last_cnt == 1 && last_c == exp_n - 1, tag, "last position (R10)", last_c, exp_n - 1);
        else           chk(last_cnt == 0, tag, "no last on empty (R10)", last_cnt, 0);
        chk(done_c == exp_n, tag, "done cycle (R11)", done_c, exp_n);
        @(negedge clk);
        chk(!done, tag, "done one cycle (R11)", int'(done), 0);
        chk(count == 4'(exp_n), tag, "reported count", int'(count), exp_n);
        chk(retry == 1'(exp_rt), tag, "retry flag", int'(retry), exp_rt);
        chk(unknown == 1'(exp_uk), tag, "unknown flag", int'(unknown), exp_uk);
    endtask

    task automatic t_reset_R1;
        chk(!valid && !last && !done, "R1", "idle outputs", int'({valid, last, done}), 0);
        chk(count == 0 && !retry && !unknown, "R1", "held status", int'({count, retry, unknown}), 0);
    endtask

    task automatic t_short_one_R2;
        run_frame("R2", mkbuf(8'h11, 8'h5A, 8'h77), 16, -1, '0);
        run_frame("R2", mkbuf(8'h21, 8'hC3, 8'h01), 16, -1, '0);
    endtask

    task automatic t_short_two_R3;
        run_frame("R3", mkbuf(8'h12, 8'hA1, 8'hB2), 16, -1, '0);
        run_frame("R3", mkbuf(8'h22, 8'h0F, 8'hF0), 16, -1, '0);
    endtask

    task automatic t_long_R4;
        run_frame("R4", mkbuf(8'h1A, 8'd5, 8'd0), 16, -1, '0);
        run_frame("R4", mkbuf(8'h1C, 8'd7, 8'd0), 16, -1, '0);
        run_frame("R4", mkbuf(8'h1A, 8'd3, 8'd0), 8, -1, '0);
    endtask

    task automatic t_offset_R5;
        run_frame("R5", mkbuf(8'h1A, 8'd2, 8'd0), 16, -1, '0);
        run_frame("R5", mkbuf(8'h1C, 8'd1, 8'd0), 16, -1, '0);
    endtask

    task automatic t_cap_R6;
        run_frame("R6", mkbuf(8'h1C, 8'd0, 8'd1), 16, -1, '0);
        run_frame("R6", mkbuf(8'h1A, 8'hFF, 8'hFF), 200, -1, '0);
        run_frame("R6", mkbuf(8'h1A, 8'd11, 8'd0), 16, -1, '0);
    endtask

    task automatic t_req_R7;
        run_frame("R7", mkbuf(8'h1A, 8'd8, 8'd0), 3, -1, '0);
        run_frame("R7", mkbuf(8'h12, 8'h33, 8'h44), 1, -1, '0);
        run_frame("R7", mkbuf(8'h11, 8'h99, 8'h00), 0, -1, '0);
        run_frame("R7", mkbuf(8'h1C, 8'd0, 8'd2), 9, -1, '0);
    endtask

    task automatic t_retry_R8;
        run_frame("R8", mkbuf(8'h02, 8'h12, 8'h34), 16, -1, '0);
    endtask

    task automatic t_unknown_R9;
        run_frame("R9", mkbuf(8'h03, 8'h12, 8'h34), 16, -1, '0);
        run_frame("R9", mkbuf(8'h1B, 8'd6, 8'd0), 16, -1, '0);
    endtask

    task automatic t_busy_start_R12;
        run_frame("R12", mkbuf(8'h1C, 8'd8, 8'd0), 16, 2, mkbuf(8'h02, 8'h00, 8'h00));
        run_frame("R12", mkbuf(8'h12, 8'h61, 8'h62), 16, 1, mkbuf(8'h1A, 8'd9, 8'd0));
    endtask

    initial begin
        #(8ns * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_R1();
        t_short_one_R2();
        t_short_two_R3();
        t_long_R4();
        t_offset_R5();
        t_cap_R6();
        t_req_R7();
        t_retry_R8();
        t_unknown_R9();
        t_busy_start_R12();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule